// File: doc/BRIEF.md
# Addressable Tap Shift Register

This block is a one-bit serial delay line whose length can be picked at run time. It is made of 16-stage segments joined end to end. On every rising clock edge with the shift enable high, a new bit enters stage 0 and every stored bit moves one stage further along. A tap address picks one stage and drives it straight onto the data output through a multiplexer, with no register on that path. Changing the address therefore changes the delay at once.

A separate chain output always carries the final stage of the last segment, whatever the address is. The segment count is a parameter from 1 to 8, so the line holds 16 to 128 stages. A bus of any width is built by placing several instances side by side and driving them with a shared enable and address. A synchronous reset clears every stage.

Top module: `tapsr_chain`

## Requirements
- R1: With the tap address set to N, inside one segment, `tap_out` shows the `din` value that was shifted in N+1 enabled edges earlier. Stage 0 holds the newest bit.
- R2: The contents shift only on a rising `clk` edge where `shift_en` is 1. While `shift_en` is 0, every stage keeps its value, and `tap_out` stays the same unless `tap_addr` changes.
- R3: `tap_out` follows `tap_addr` combinationally. A new address is reflected within the same clock cycle, with no clock edge needed.
- R4: `chain_out` always equals the last stage of the last segment, at position NUM_SEG*16-1, whatever the value of `tap_addr`. It is therefore `din` delayed by NUM_SEG*16 enabled edges.
- R5: Stage 0 of segment k is loaded from stage 15 of segment k-1. `tap_addr[3:0]` selects the stage within a segment and the upper address bits select the segment. Position p = segment*16 + stage gives a delay of p+1 enabled edges, and this holds across segment boundaries, for example between positions 15 and 16.
- R6: A rising edge with `rst` at 1 clears all stages to 0, so `tap_out` reads 0 at every address and `chain_out` reads 0. `rst` takes priority over `shift_en`.
- R7: A `tap_addr` whose segment field is NUM_SEG or greater makes `tap_out` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all stages |
| shift_en | input | 1 | Shift enable |
| din | input | 1 | Serial data into stage 0 of segment 0 |
| tap_addr | input | ADDR_W | Bits [3:0] select the stage, upper bits select the segment |
| tap_out | output | 1 | Selected stage, combinational from `tap_addr` |
| chain_out | output | 1 | Last stage of the last segment |

## Verification
A single marked 1 is shifted in through a stream of 0s, so a delay that is off by one stage shows up as a bit in the wrong place. Patterns with the enable low separate a true hold from a shift that leaks through. Sweeping the address with the clock stopped shows whether the tap path is really combinational and whether each stage maps to the correct position. This sweep includes the boundaries between segments and the out-of-range segment codes. Long random runs of data, enable and address patterns are compared against a queue model, which checks the tap output and the chain output together.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  localparam int SEG_LEN   = 16;
  localparam int STAGE_W   = $clog2(SEG_LEN);
  localparam int MAX_SEGS  = 8;
endpackage

// File: rtl/tapsr_sel.sv
module tapsr_sel #(
  parameter int N_IN  = 16,
  parameter int SEL_W = 4
) (
  input  logic [N_IN-1:0]  vec,
  input  logic [SEL_W-1:0] sel,
  output logic             o
);
  always_comb begin
    o = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (sel == SEL_W'(i)) o = vec[i];
    end
  end
endmodule

// File: rtl/tapsr_segment.sv
module tapsr_segment
  import tapsr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               ser_in,
  input  logic [STAGE_W-1:0] stage_sel,
  output logic               tap,
  output logic               last
);
  logic [SEG_LEN-1:0] stages;

  always_ff @(posedge clk) begin
    if (rst)           stages <= '0;
    else if (shift_en) stages <= {stages[SEG_LEN-2:0], ser_in};
  end

  tapsr_sel #(.N_IN(SEG_LEN), .SEL_W(STAGE_W)) stage_mux_i (
    .vec(stages), .sel(stage_sel), .o(tap)
  );

  assign last = stages[SEG_LEN-1];
endmodule

// File: rtl/tapsr_chain.sv
module tapsr_chain
  import tapsr_pkg::*;
#(
  parameter  int NUM_SEG   = 4,
  localparam int SEG_SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int ADDR_W    = STAGE_W + SEG_SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic [ADDR_W-1:0] tap_addr,
  output logic              tap_out,
  output logic              chain_out
);
  logic [NUM_SEG-1:0] seg_tap;
  logic [NUM_SEG-1:0] seg_last;
  logic [NUM_SEG-1:0] seg_in;
  logic [SEG_SEL_W-1:0] seg_sel;

  assign seg_sel = tap_addr[ADDR_W-1:STAGE_W];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    if (g == 0) begin : g_head
      assign seg_in[g] = din;
    end else begin : g_link
      assign seg_in[g] = seg_last[g-1];
    end
    tapsr_segment seg_i (
      .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(seg_in[g]),
      .stage_sel(tap_addr[STAGE_W-1:0]),
      .tap(seg_tap[g]), .last(seg_last[g])
    );
  end

  tapsr_sel #(.N_IN(NUM_SEG), .SEL_W(SEG_SEL_W)) seg_mux_i (
    .vec(seg_tap), .sel(seg_sel), .o(tap_out)
  );

  assign chain_out = seg_last[NUM_SEG-1];
endmodule

// File: rtl/tapsr_chain_chk.sv
module tapsr_chain_chk
  import tapsr_pkg::*;
#(
  parameter  int NUM_SEG   = 4,
  localparam int SEG_SEL_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int ADDR_W    = STAGE_W + SEG_SEL_W,
  localparam int LAST_POS  = NUM_SEG * SEG_LEN - 1
) (
  input logic              clk,
  input logic              rst,
  input logic              shift_en,
  input logic              din,
  input logic [ADDR_W-1:0] tap_addr,
  input logic              tap_out,
  input logic              chain_out
);
  a_r1_first_stage: assert property (@(posedge clk) disable iff (rst)
    (shift_en && tap_addr == '0) |=> (tap_addr != '0) || (tap_out == $past(din)));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> (tap_addr != $past(tap_addr)) || $stable(tap_out));

  a_r4_chain_end: assert property (@(posedge clk) disable iff (rst)
    (shift_en && tap_addr == ADDR_W'(LAST_POS - 1)) |=> (chain_out == $past(tap_out)));

  a_r5_boundary: assert property (@(posedge clk) disable iff (rst)
    (NUM_SEG > 1 && shift_en && tap_addr == ADDR_W'(SEG_LEN - 1))
      |=> (tap_addr != ADDR_W'(SEG_LEN)) || (tap_out == $past(tap_out)));

  a_r6_clear: assert property (@(posedge clk)
    rst |=> (tap_out == 1'b0) && (chain_out == 1'b0));

  a_r7_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (int'(tap_addr) > LAST_POS) |-> (tap_out == 1'b0));
endmodule

bind tapsr_chain tapsr_chain_chk #(.NUM_SEG(NUM_SEG)) chk_i (
  .clk(clk), .rst(rst), .shift_en(shift_en), .din(din),
  .tap_addr(tap_addr), .tap_out(tap_out), .chain_out(chain_out)
);

// File: tb/tapsr_chain_tb_top.sv
`timescale 1ns/1ps
module tapsr_chain_tb_top;
  localparam int NSEG  = 3;
  localparam int TOTAL = NSEG * 16;
  localparam int AW    = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic din = 1'b0;
  logic [AW-1:0] tap_addr = '0;
  logic tap_out, chain_out;

  logic [TOTAL-1:0] model = '0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tapsr_chain #(.NUM_SEG(NSEG)) dut_i (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(din),
    .tap_addr(tap_addr), .tap_out(tap_out), .chain_out(chain_out)
  );

  function automatic logic exp_tap(input logic [AW-1:0] a);
    return (int'(a) < TOTAL) ? model[a] : 1'b0;
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (addr=%0d)", tag, act, exp, tap_addr);
    end
  endtask

  task automatic step(input logic d, input logic c, input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    din = d; shift_en = c; tap_addr = a;
    @(posedge clk);
    if (c) model = {model[TOTAL-2:0], d};
    #1;
    check({tag, " tap"}, tap_out, exp_tap(a));
    check("R4 chain", chain_out, model[TOTAL-1]);
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < (1 << AW); a++) begin
      tap_addr = AW'(a);
      #0.1;
      check(tag, tap_out, exp_tap(AW'(a)));
    end
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; shift_en = 1'b1; din = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    model = '0;
    @(negedge clk); rst = 1'b0; shift_en = 1'b0;
    sweep("R6 cleared");
    check("R6 chain cleared", chain_out, 1'b0);
  endtask

  task automatic t_single_bit();
    step(1'b1, 1'b1, AW'(5), "R1 marker in");
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b1, AW'(5), "R1 marker walk");
    end
    check("R1 marker at 6 edges gone past", tap_out, 1'b0);
    for (int k = 0; k < TOTAL; k++) step(1'b0, 1'b1, AW'(0), "R1 flush");
  endtask

  task automatic t_hold();
    for (int k = 0; k < 20; k++) step(1'($urandom), 1'b1, AW'(k), "R2 load");
    for (int k = 0; k < 20; k++) step(1'($urandom), 1'b0, AW'(k % TOTAL), "R2 hold");
    @(negedge clk); shift_en = 1'b0;
    sweep("R2 after hold");
  endtask

  task automatic t_comb_addr();
    @(negedge clk); shift_en = 1'b0;
    sweep("R3 comb sweep");
  endtask

  task automatic t_boundary();
    for (int k = 0; k < TOTAL; k++) step(1'($urandom), 1'b1, AW'(15), "R5 pre 15");
    step(1'b1, 1'b1, AW'(15), "R5 at 15");
    step(1'b0, 1'b1, AW'(16), "R5 at 16");
    step(1'b1, 1'b1, AW'(31), "R5 at 31");
    step(1'b0, 1'b1, AW'(32), "R5 at 32");
    step(1'b1, 1'b1, AW'(TOTAL-1), "R5 at last");
  endtask

  task automatic t_out_of_range();
    for (int k = 0; k < TOTAL; k++) step(1'b1, 1'b1, AW'(TOTAL + (k % 16)), "R7 high");
    @(negedge clk); shift_en = 1'b0;
    for (int a = TOTAL; a < (1 << AW); a++) begin
      tap_addr = AW'(a); #0.1;
      check("R7 out of range", tap_out, 1'b0);
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 2000; k++)
      step(1'($urandom), ($urandom % 4) != 0, AW'($urandom), "R1 R5 random");
  endtask

  initial begin
    t_reset();
    t_single_bit();
    t_hold();
    t_comb_addr();
    t_boundary();
    t_out_of_range();
    t_random();
    t_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule